// File: doc/BRIEF.md
# Predicated Element Write-Lane Sequencer

This block walks through the elements of a single vector operation, one element per accepted transfer. For every element it names the destination register in a 128-entry register file, the byte lane inside that 64-bit register where the element starts, and a byte write-enable vector. With these enables the register file can write the element directly, with no read-modify-write. Elements are packed from the least significant byte of a register upward. When a register fills, the next element goes to the following register.

A start strobe captures the operation's settings: vector length, sub-vector group code, element-width code, base register and vector/scalar tag. An external mask unit supplies one predicate bit per sub-vector group. It watches the element index that the block presents and drives the bit for the group that element belongs to. An element with a false predicate is still issued and still uses up its index, but all of its byte enables are low.

The element stream leaves on a valid/ready pair. An element counts as delivered only in a cycle where valid and ready are both high. While ready is low, the presented element and all of its fields are held unchanged. The start strobe and the done pulse are plain control pins.

Top module: `elem_lane_seq`

## Requirements
- R1: The element-width code gives the element size: 00 = 8 bytes (64-bit), 01 = 4 bytes, 10 = 2 bytes, 11 = 1 byte. A predicated-on element enables exactly that many byte lanes.
- R2: For a vector operand, the element at step k of size b bytes goes to register (base + (k*b)/8) mod 128 at byte lane (k*b) mod 8. Numbering wraps past register 127 to 0.
- R3: A predicated-on element's enables are a contiguous run starting at its byte lane (bit j of the enable vector = byte j). When the predicate is 0, all eight enables are low.
- R4: Steps are issued in ascending order from 0. The index advances by exactly one per accepted transfer.
- R5: With a vector length of 0, no element is ever presented, and the done pulse appears in the cycle after the start strobe.
- R6: Sub-vector code 00/01/10/11 selects groups of 1/2/3/4 elements. The operation issues vector-length × group-size steps, and all steps of one group share one predicate bit.
- R7: For a scalar-tagged operand, every step uses the base register at byte lane 0.
- R8: While valid is high and ready is low, valid stays high and the index, register, lane and enables do not change.
- R9: A start strobe while an operation is in progress is ignored. The sequence continues with the settings captured at its own start.
- R10: Done goes high for exactly one cycle, in the cycle after the last element is accepted. Valid is low in that cycle.
- R11: After reset, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (used only while idle) |
| vl_i | input | VL_W | Vector length |
| subvl_i | input | 2 | Sub-vector group code |
| ew_i | input | 2 | Element-width code |
| base_i | input | REG_AW | Base destination register |
| is_vec_i | input | 1 | 1 = vector operand, 0 = scalar operand |
| pred_i | input | 1 | Predicate bit for the presented element's group |
| elem_valid_o | output | 1 | An element is presented |
| elem_ready_i | input | 1 | Downstream accepts the presented element |
| elem_idx_o | output | VL_W+2 | Step index of the presented element |
| reg_o | output | REG_AW | Destination register number |
| lane_o | output | 3 | Starting byte lane within the register |
| byte_we_o | output | 8 | Byte write enables |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every element-width code against every group code and several vector lengths, including zero, for both vector and scalar tags. Width errors and packing errors therefore show up as wrong lanes, wrong enable counts, or a register carry at the wrong step. Base registers near the top of the file separate correct modulo-128 wrapping from saturation. A rotating, uneven predicate mask driven per group shows whether a false predicate clears the enables without stopping the index, and whether group boundaries fall at the right step. Some runs stall the ready input and pulse a stray start mid-operation with different settings, which separates correct holding and start-ignoring from a design that re-launches or skips elements.

// File: rtl/elem_lane_pkg.sv
package elem_lane_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int NB_W   = LANE_W + 1;

  typedef enum logic [1:0] {
    EW_FULL = 2'b00,
    EW_HALF = 2'b01,
    EW_QTR  = 2'b10,
    EW_BYTE = 2'b11
  } ew_code_e;
endpackage

// File: rtl/elw_decode.sv
module elw_decode
  import elem_lane_pkg::*;
(
  input  ew_code_e          ew,
  output logic [NB_W-1:0]   nbytes
);
  // Bytes per element halve with each code step.
  always_comb begin
    unique case (ew)
      EW_FULL: nbytes = NB_W'(LANES);
      EW_HALF: nbytes = NB_W'(LANES / 2);
      EW_QTR:  nbytes = NB_W'(LANES / 4);
      default: nbytes = NB_W'(LANES / 8);
    endcase
  end

  always_comb begin
    assert ($countones(nbytes) == 1) else $error("p_width_pow2_r1");
  end
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl #(
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STEP_W-1:0] total,
  input  logic              adv,
  output logic              busy,
  output logic [STEP_W-1:0] idx,
  output logic              last,
  output logic              done
);
  logic [STEP_W-1:0] total_q;

  assign last = busy && (idx == total_q - STEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      total_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        idx     <= '0;
        total_q <= total;
        if (total == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end else if (busy && adv) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + STEP_W'(1);
        end
      end
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adv && !last) |=> (busy && idx == $past(idx) + STEP_W'(1)));
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < total_q));
endmodule

// File: rtl/lane_addr.sv
module lane_addr
  import elem_lane_pkg::*;
#(
  parameter int REG_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [REG_AW-1:0] base,
  input  logic              is_vec,
  input  logic [NB_W-1:0]   nbytes,
  input  logic              adv,
  output logic [REG_AW-1:0] reg_num,
  output logic [LANE_W-1:0] lane
);
  localparam int POS_W = REG_AW + LANE_W;

  // Register and lane form one byte position; carry out of the lane
  // field steps the register, wrapping at the top of the file.
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (load) begin
      pos_q <= {base, LANE_W'(0)};
    end else if (adv && is_vec) begin
      pos_q <= pos_q + POS_W'(nbytes);
    end
  end

  assign reg_num = pos_q[POS_W-1:LANE_W];
  assign lane    = pos_q[LANE_W-1:0];

  p_lane_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((NB_W'(lane) & (nbytes - NB_W'(1))) == '0));
  p_scalar_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !is_vec) |=> $stable(pos_q));
endmodule

// File: rtl/we_expand.sv
module we_expand
  import elem_lane_pkg::*;
(
  input  logic              en,
  input  logic              pred,
  input  logic [LANE_W-1:0] lane,
  input  logic [NB_W-1:0]   nbytes,
  output logic [LANES-1:0]  we
);
  logic [NB_W-1:0] lane_ext;
  logic [NB_W-1:0] lane_end;

  assign lane_ext = NB_W'(lane);
  assign lane_end = lane_ext + nbytes;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign we[j] = en && pred &&
                   (NB_W'(j) >= lane_ext) && (NB_W'(j) < lane_end);
  end

  always_comb begin
    if (en && pred)
      assert ($countones(we) == int'(nbytes)) else $error("p_we_count_r1");
    else
      assert (we == '0) else $error("p_we_off_r3");
  end
endmodule

// File: rtl/elem_lane_seq.sv
module elem_lane_seq
  import elem_lane_pkg::*;
#(
  parameter int VL_W   = 7,
  parameter int REG_AW = 7,
  localparam int STEP_W = VL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [1:0]        subvl_i,
  input  logic [1:0]        ew_i,
  input  logic [REG_AW-1:0] base_i,
  input  logic              is_vec_i,
  input  logic              pred_i,
  output logic              elem_valid_o,
  input  logic              elem_ready_i,
  output logic [STEP_W-1:0] elem_idx_o,
  output logic [REG_AW-1:0] reg_o,
  output logic [LANE_W-1:0] lane_o,
  output logic [LANES-1:0]  byte_we_o,
  output logic              done_o
);
  logic              busy, last, load, adv;
  logic [STEP_W-1:0] total;
  ew_code_e          ew_q;
  logic              vec_q;
  logic [NB_W-1:0]   nbytes;

  assign load  = start_i && !busy;
  assign adv   = busy && elem_ready_i;
  assign total = STEP_W'(vl_i) * (STEP_W'(subvl_i) + STEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ew_q  <= EW_FULL;
      vec_q <= 1'b0;
    end else if (load) begin
      ew_q  <= ew_code_e'(ew_i);
      vec_q <= is_vec_i;
    end
  end

  elw_decode u_dec (
    .ew     (ew_q),
    .nbytes (nbytes)
  );

  step_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .total (total),
    .adv   (adv),
    .busy  (busy),
    .idx   (elem_idx_o),
    .last  (last),
    .done  (done_o)
  );

  lane_addr #(.REG_AW(REG_AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .base    (base_i),
    .is_vec  (vec_q),
    .nbytes  (nbytes),
    .adv     (adv && !last),
    .reg_num (reg_o),
    .lane    (lane_o)
  );

  we_expand u_we (
    .en     (busy),
    .pred   (pred_i),
    .lane   (lane_o),
    .nbytes (nbytes),
    .we     (byte_we_o)
  );

  assign elem_valid_o = busy;

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid_o && !elem_ready_i) |=>
      (elem_valid_o && $stable(elem_idx_o) && $stable(reg_o) && $stable(lane_o)));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid_o && start_i && elem_ready_i && !last) |=>
      (elem_valid_o && elem_idx_o != '0));
  p_we_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !elem_valid_o |-> (byte_we_o == '0));
endmodule

// File: tb/elem_lane_seq_tb.sv
module elem_lane_seq_tb;
  localparam int VL_W   = 7;
  localparam int REG_AW = 7;
  localparam int STEP_W = VL_W + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [VL_W-1:0]   vl_i = '0;
  logic [1:0]        subvl_i = '0;
  logic [1:0]        ew_i = '0;
  logic [REG_AW-1:0] base_i = '0;
  logic              is_vec_i = 1'b0;
  logic              pred_i;
  logic              elem_valid_o;
  logic              elem_ready_i = 1'b1;
  logic [STEP_W-1:0] elem_idx_o;
  logic [REG_AW-1:0] reg_o;
  logic [2:0]        lane_o;
  logic [7:0]        byte_we_o;
  logic              done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] mask_q = 8'hFF;
  int         grp_n  = 1;

  always #5 clk = ~clk;

  // Mask unit model: one bit per sub-vector group.
  always_comb pred_i = mask_q[(int'(elem_idx_o) / grp_n) % 8];

  elem_lane_seq #(.VL_W(VL_W), .REG_AW(REG_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .subvl_i(subvl_i), .ew_i(ew_i), .base_i(base_i), .is_vec_i(is_vec_i),
    .pred_i(pred_i), .elem_valid_o(elem_valid_o), .elem_ready_i(elem_ready_i),
    .elem_idx_o(elem_idx_o), .reg_o(reg_o), .lane_o(lane_o),
    .byte_we_o(byte_we_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic run_op(input int ew, input int sv, input int vl, input bit vec,
                        input int base, input logic [7:0] mask,
                        input bit stall, input bit inject);
    int b, total, k, n, exp_reg, exp_lane, exp_we;
    bit rdy, injected;
    b = 8 >> ew;
    total = vl * (sv + 1);
    @(negedge clk);
    ew_i = 2'(ew); subvl_i = 2'(sv); vl_i = VL_W'(vl);
    is_vec_i = vec; base_i = REG_AW'(base);
    mask_q = mask; grp_n = sv + 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (total == 0) begin
      chk(done_o && !elem_valid_o, "R5 done without elements", int'(done_o), 1);
      @(negedge clk);
      chk(!done_o && !elem_valid_o, "R10 done single cycle", int'(done_o), 0);
      return;
    end
    k = 0; n = 0; injected = 0;
    while (k < total) begin
      rdy = stall ? ((n % 3) != 2) : 1'b1;
      elem_ready_i = rdy;
      if (inject && !injected && k == 1) begin
        start_i = 1'b1; vl_i = '0; ew_i = 2'(ew ^ 1); base_i = REG_AW'(base + 9);
        is_vec_i = ~vec;
        injected = 1;
      end
      exp_reg  = vec ? (base + (k * b) / 8) % 128 : base;
      exp_lane = vec ? (k * b) % 8 : 0;
      exp_we   = mask[(k / (sv + 1)) % 8] ? ((((1 << b) - 1) << exp_lane) & 255) : 0;
      chk(elem_valid_o == 1'b1, "R4 valid during op", int'(elem_valid_o), 1);
      chk(int'(elem_idx_o) == k, "R4 R9 step index", int'(elem_idx_o), k);
      chk(int'(reg_o) == exp_reg, vec ? "R2 register" : "R7 scalar register",
          int'(reg_o), exp_reg);
      chk(int'(lane_o) == exp_lane, vec ? "R2 lane" : "R7 scalar lane",
          int'(lane_o), exp_lane);
      chk(int'(byte_we_o) == exp_we, "R1 R3 R6 byte enables", int'(byte_we_o), exp_we);
      if (rdy) k++;
      n++;
      @(negedge clk);
      start_i = 1'b0;
      if (!rdy && stall)
        chk(elem_valid_o && int'(elem_idx_o) == k, "R8 hold under stall",
            int'(elem_idx_o), k);
    end
    elem_ready_i = 1'b1;
    chk(done_o && !elem_valid_o, "R6 R10 done after last step", int'(done_o), 1);
    @(negedge clk);
    chk(!done_o, "R10 done single cycle", int'(done_o), 0);
  endtask

  initial begin
    int vls[4];
    vls = '{0, 1, 3, 6};
    repeat (3) @(negedge clk);
    chk(!elem_valid_o && !done_o, "R11 reset state", int'(elem_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!elem_valid_o && !done_o, "R11 idle after reset", int'(done_o), 0);
    for (int ew = 0; ew < 4; ew++)
      for (int sv = 0; sv < 4; sv++)
        for (int vi = 0; vi < 4; vi++)
          for (int vec = 0; vec < 2; vec++)
            run_op(ew, sv, vls[vi], vec[0],
                   (ew * 37 + sv * 11 + vi * 5 + vec * 60) % 128,
                   8'hB6 ^ 8'(ew * 16 + sv * 3 + vi),
                   ((ew + sv) % 2) == 1, vls[vi] == 3);
    // Wrap past the last register.
    run_op(0, 0, 5, 1'b1, 126, 8'hFF, 1'b0, 1'b0);
    run_op(1, 1, 6, 1'b1, 127, 8'h5A, 1'b1, 1'b1);
    run_op(3, 3, 20, 1'b1, 125, 8'hC3, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule